// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo PCM from a three-wire serial port: a bit clock, a frame clock that marks the left and right halves of each frame, and one data line. It is clocked directly by the bit clock. It decodes I2S, left-justified and right-justified framing, with 16-, 20- or 24-bit samples and 32, 48 or 64 bit clocks per frame. Two static select inputs pick the framing and the word size.

For every complete frame, the receiver presents a signed 24-bit left sample and a signed 24-bit right sample together, with a one-cycle valid strobe. Shorter words are placed in the upper bits, and the unused low bits are zero. The I2S case is handled by delaying the frame clock by one bit clock, which turns it into left-justified framing. Right-justified words are taken from the last bits of each half-frame, at the frame clock change that ends that half.

Top module: `serial_audio_rx`

## Requirements
- R1: Select encodings: `fmt` 0 = I2S, 1 = left-justified, 2 = right-justified, 3 behaves as I2S. `wsize` 0 = 24 bits, 1 = 20 bits, 2 = 16 bits, 3 behaves as 24 bits. So all-zero selects, the reset default, mean 24-bit I2S.
- R2: In I2S, a low frame clock marks the left channel and a high one the right channel. The MSB is on the bit clock after the one on which the frame clock is first seen at its new level.
- R3: In left-justified mode, a high frame clock marks the left channel. The MSB is on the first bit clock at which the frame clock is seen at its new level.
- R4: In right-justified mode, a high frame clock marks the left channel. The LSB is on the last bit clock of each half-frame, so the position of the MSB depends on the word size.
- R5: Samples are two's complement and sent MSB first. A 20- or 16-bit word appears in bits 23 down of the output, and the remaining low bits are zero.
- R6: Left and right update together, only on a cycle where `valid` is high. `valid` is high for exactly one bit clock per frame, after the right word is complete.
- R7: After reset, `left`, `right` and `valid` are zero. No word is taken from the half-frame that is in progress when reset ends; capture starts at the first frame clock change seen after reset.
- R8: Decoding is correct with 16, 24 or 32 bit clocks per half-frame, provided the word fits in the half-frame.
- R9: A right word with no left word captured before it in the same frame produces no `valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; data and frame clock are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lrclk | input | 1 | Frame clock selecting the channel |
| sdata | input | 1 | Serial data, MSB first |
| fmt | input | 2 | Framing select (R1) |
| wsize | input | 2 | Word size select (R1) |
| left | output | 24 | Left sample, left-aligned two's complement |
| right | output | 24 | Right sample, left-aligned two's complement |
| valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The bench targets the following corner cases:

- **16-bit I2S at 32 bit clocks per frame.** The LSB of each word arrives on the first bit clock of the following half-frame. A receiver that closed the word on the frame clock change would lose that bit, or would give it to the wrong channel.
- **Right-justified words shorter than the half-frame.** A receiver that counted from the start of the half would return shifted garbage.
- **A stream that starts in the middle of a frame after reset.** A receiver without the arming rule would emit a pair built from a partial left word.
- **A right word with no left word before it.** A receiver without the pairing rule would emit a pair containing a stale left value.

Sign-carrying and all-ones-low patterns in 20- and 16-bit modes show whether the low bits are zero-filled or carry leftover shift contents.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 7
) (
  input  logic                bclk,
  input  logic                rst_n,
  input  logic                lrclk,
  input  logic                sdata,
  input  logic [1:0]          fmt,
  input  logic [1:0]          wsize,
  output logic [SAMPLE_W-1:0] left,
  output logic [SAMPLE_W-1:0] right,
  output logic                valid
);
  localparam int MID_W   = SAMPLE_W - 4;
  localparam int SHORT_W = SAMPLE_W - 8;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                lr_dly, lr_prev, armed, have_l;
  logic [1:0]          prime;
  logic [CNT_W-1:0]    cnt, idx, wlen;
  logic [SAMPLE_W-1:0] sh, nxt, raw, word, hold_l;
  logic                is_i2s, is_rj, lr_eng, edge_seen, take;
  logic                lj_done, rj_done, done, done_right;

  assign is_rj  = fmt == 2'd2;
  assign is_i2s = fmt[0] == fmt[1];
  // I2S becomes left-justified once the frame clock is delayed by one bit
  assign lr_eng    = is_i2s ? lr_dly : lrclk;
  assign edge_seen = prime[1] && (lr_eng != lr_prev);
  assign idx       = edge_seen ? '0 : cnt;

  always_comb begin
    case (wsize)
      2'd1:    wlen = CNT_W'(MID_W);
      2'd2:    wlen = CNT_W'(SHORT_W);
      default: wlen = CNT_W'(SAMPLE_W);
    endcase
  end

  assign take    = is_rj || (idx < wlen);
  assign nxt     = {sh[SAMPLE_W-2:0], sdata};
  assign lj_done = !is_rj && armed && !edge_seen && (idx == wlen - 1'b1);
  assign rj_done = is_rj && armed && edge_seen;
  assign done    = lj_done || rj_done;
  assign done_right = (is_rj ? lr_prev : lr_eng) ^ !is_i2s;
  assign raw     = is_rj ? sh : nxt;

  always_comb begin
    case (wsize)
      2'd1:    word = {raw[MID_W-1:0], 4'b0};
      2'd2:    word = {raw[SHORT_W-1:0], 8'b0};
      default: word = raw;
    endcase
  end

  always_ff @(posedge bclk) begin
    if (!rst_n) begin
      prime   <= '0;
      lr_dly  <= 1'b0;
      lr_prev <= 1'b0;
      armed   <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      hold_l  <= '0;
      have_l  <= 1'b0;
      left    <= '0;
      right   <= '0;
      valid   <= 1'b0;
    end else begin
      prime   <= {prime[0], 1'b1};
      lr_dly  <= lrclk;
      lr_prev <= lr_eng;
      if (edge_seen) armed <= 1'b1;
      cnt   <= edge_seen ? CNT_W'(1) : ((cnt == CNT_MAX) ? cnt : cnt + 1'b1);
      if (take) sh <= nxt;
      valid <= 1'b0;
      if (done) begin
        if (!done_right) begin
          hold_l <= word;
          have_l <= 1'b1;
        end else if (have_l) begin
          left   <= hold_l;
          right  <= word;
          valid  <= 1'b1;
          have_l <= 1'b0;
        end
      end
    end
  end

  a_r6_single_strobe: assert property (@(posedge bclk) disable iff (!rst_n)
    valid |=> !valid);

  a_r6_update_with_strobe: assert property (@(posedge bclk) disable iff (!rst_n)
    (left != $past(left) || right != $past(right)) |-> valid);

  a_r7_quiet_until_armed: assert property (@(posedge bclk) disable iff (!rst_n)
    !armed |-> !valid);

  a_r9_pair_needs_left: assert property (@(posedge bclk) disable iff (!rst_n)
    $rose(valid) |-> $past(have_l));

  a_r5_short_low_zero: assert property (@(posedge bclk) disable iff (!rst_n)
    (valid && wsize == 2'd2) |-> (left[SAMPLE_W-SHORT_W-1:0] == '0 && right[SAMPLE_W-SHORT_W-1:0] == '0));

endmodule

// File: tb/test_serial_audio_rx.sv
`timescale 1ns/1ps
module test_serial_audio_rx;
  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lrclk = 1'b0;
  logic        sdata = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic [1:0]  wsize = 2'd0;
  logic [23:0] left, right;
  logic        valid;

  int checks = 0;
  int fails = 0;
  int nvalid = 0;
  logic [23:0] exp_l = '0, exp_r = '0;
  logic [23:0] prev_l = '0, prev_r = '0;
  logic        prev_v = 1'b0;
  string       cur_tag = "R7";

  serial_audio_rx i_serial_audio_rx (
    .bclk(bclk), .rst_n(rst_n), .lrclk(lrclk), .sdata(sdata),
    .fmt(fmt), .wsize(wsize), .left(left), .right(right), .valid(valid)
  );

  always #2 bclk = ~bclk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge bclk) begin
    if (rst_n) begin
      if (valid) begin
        nvalid++;
        check(left == exp_l, {cur_tag, " left"}, {8'h0, left}, {8'h0, exp_l});
        check(right == exp_r, {cur_tag, " right"}, {8'h0, right}, {8'h0, exp_r});
        if (prev_v) check(1'b0, "R6 strobe longer than one cycle", 32'd1, 32'd0);
      end else if (left != prev_l || right != prev_r) begin
        check(1'b0, "R6 output changed without strobe", {8'h0, left}, {8'h0, prev_l});
      end
    end
    prev_l = left;
    prev_r = right;
    prev_v = valid;
  end

  task automatic drive(input logic lr, input logic sd);
    @(negedge bclk);
    lrclk = lr;
    sdata = sd;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge bclk);
    rst_n = 1'b1;
    @(negedge bclk);
    check(valid == 1'b0 && left == '0 && right == '0, "R7 reset state",
          {7'h0, valid, left}, 32'h0);
  endtask

  function automatic logic [23:0] trunc(input logic [1:0] ws, input logic [23:0] v);
    case (ws)
      2'd1:    return v & 24'hFFFFF0;
      2'd2:    return v & 24'hFFFF00;
      default: return v;
    endcase
  endfunction

  task automatic run_vec(input logic [1:0] f, input logic [1:0] ws, input int h,
                         input logic [23:0] l, input logic [23:0] r, input int nfr,
                         input bit junk_lead, input string tag);
    bit   i2s = (f == 2'd0) || (f == 2'd3);
    bit   rj  = (f == 2'd2);
    logic left_lvl = i2s ? 1'b0 : 1'b1;
    int   w = (ws == 2'd1) ? 20 : ((ws == 2'd2) ? 16 : 24);
    int   base = junk_lead ? 2 : 1;
    int   nh = 2 * nfr + base + 1;
    logic prevbit = 1'b0;
    logic lr = 1'b0;
    fmt = f;
    wsize = ws;
    exp_l = trunc(ws, l);
    exp_r = trunc(ws, r);
    cur_tag = tag;
    lrclk = junk_lead ? left_lvl : ~left_lvl;
    sdata = 1'b0;
    do_reset();
    nvalid = 0;
    for (int hh = 0; hh < nh; hh++) begin
      bit is_left;
      logic [23:0] wd;
      int k = hh - base;
      if (junk_lead && hh == 0) begin is_left = 1; wd = 24'hC3A5F0; end
      else if (junk_lead && hh == 1) begin is_left = 0; wd = 24'h5A5A5A; end
      else if (!junk_lead && hh == 0) begin is_left = 0; wd = 24'h0; end
      else if (k < 2 * nfr) begin is_left = (k % 2) == 0; wd = is_left ? l : r; end
      else begin is_left = 1; wd = 24'h0; end
      lr = is_left ? left_lvl : ~left_lvl;
      for (int i = 0; i < h; i++) begin
        logic b;
        if (rj) b = (i >= h - w) ? wd[23 - (i - (h - w))] : 1'b0;
        else    b = (i < w) ? wd[23 - i] : 1'b0;
        drive(lr, i2s ? prevbit : b);
        prevbit = b;
      end
    end
    repeat (4) drive(lr, 1'b0);
    check(nvalid == nfr, {tag, " R6 pair count"}, nvalid, nfr);
  endtask

  // fields: fmt[58:57] wsize[56:55] half-frame length[54:48] left[47:24] right[23:0]
  localparam logic [58:0] VECS [11] = '{
    {2'd0, 2'd0, 7'd32, 24'h123456, 24'hFEDCBA},  // R1 default 24-bit I2S
    {2'd0, 2'd2, 7'd16, 24'h8001FF, 24'h7FFEFF},  // LSB spills into next half
    {2'd0, 2'd1, 7'd24, 24'hA5A5AF, 24'h5A5A5F},
    {2'd1, 2'd0, 7'd32, 24'h800001, 24'h7FFFFE},
    {2'd1, 2'd2, 7'd16, 24'hC0037F, 24'h3FFC80},
    {2'd1, 2'd1, 7'd24, 24'hF0F0FF, 24'h0F0F0F},
    {2'd2, 2'd0, 7'd24, 24'h13579B, 24'hECA864},
    {2'd2, 2'd2, 7'd32, 24'h9ABCFF, 24'h6543FF},
    {2'd2, 2'd1, 7'd24, 24'hFFFFFF, 24'h00001F},
    {2'd3, 2'd3, 7'd32, 24'h0F1E2D, 24'hF0E1D2},  // R1 reserved codes
    {2'd2, 2'd0, 7'd32, 24'h800000, 24'h7FFFFF}
  };

  initial begin
    repeat (200000) @(posedge bclk);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int v = 0; v < 11; v++) begin
      logic [58:0] e = VECS[v];
      string ft;
      case (e[58:57])
        2'd0: ft = "R2";
        2'd1: ft = "R3";
        2'd2: ft = "R4";
        default: ft = "R1";
      endcase
      if (e[56:55] == 2'd1 || e[56:55] == 2'd2) ft = {ft, "/R5"};
      run_vec(e[58:57], e[56:55], int'(e[54:48]), e[47:24], e[23:0], 2, 1'b0,
              $sformatf("%s/R8 v%0d", ft, v));
    end
    // R7 and R9: stream begins mid-frame, junk left then unpaired right
    run_vec(2'd1, 2'd0, 32, 24'h246801, 24'h97531F, 1, 1'b1, "R7/R9 left-justified");
    run_vec(2'd2, 2'd2, 24, 24'h4321FF, 24'hBCDEFF, 1, 1'b1, "R7/R9 right-justified");
    run_vec(2'd0, 2'd1, 32, 24'h0ABCDF, 24'hF5432F, 1, 1'b1, "R7/R9 I2S");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule